// File: doc/BRIEF.md
# Two-Level Interrupt Cause Aggregator

This block collects interrupt events for a DMA endpoint into three groups (receive, transmit and miscellaneous) and reduces them to one level-sensitive host interrupt. Each group holds a 32-bit cause register that latches event pulses, a mask, and a per-bit clear-mode selector. The clear mode decides how each cause bit is cleared: either by reading the cause register, or by writing a 1 to that bit.

A second-level summary register holds one sticky bit per group. A group sets its bit while it has any unmasked pending cause. The summary clears itself when software reads it. A software gate register then blocks or passes each summary bit before they are ORed into the registered host interrupt line.

Software reaches every register over a simple 32-bit read/write bus with byte addresses. Read data is registered and appears on the cycle after the read strobe. A read's clearing side effects take place at the same clock edge that captures the data.

Top module: `irq_cause_agg`

## Requirements
- R1: After reset, every group's mask reads 0xFFFFFFFF, every clear-mode register reads 0, every cause register reads 0, the summary reads 0, the software gate reads 0xFFFFFFFF and `irq_o` is 0.
- R2: Group bases are RX 0x00, TX 0x20 and MISC 0x40. Offset 0x00 is the cause register. A 1 on an event input bit sets that cause bit on the next clock edge, whatever the mask holds.
- R3: A write to the cause register (offset 0x00) clears each bit where the data has a 1 and the clear-mode bit is 0. Cause bits whose clear-mode bit is 1 ignore the write.
- R4: Offset 0x14 is the clear-mode register (read/write). A read of the cause register returns its value and clears every cause bit whose clear-mode bit is 1.
- R5: A write to offset 0x04 sets the mask bits where the data has ones. A write to offset 0x08 clears them. Offset 0x0C reads back the current mask.
- R6: Offset 0x10 reads cause AND NOT mask. Such a read clears only the cause bits that are unmasked and have clear-mode 1.
- R7: The summary register at 0x60 has bit 0 for RX, bit 1 for TX and bit 2 for MISC. A bit is set while its group has any unmasked cause bit, and it stays set until the summary is read. A read clears it unless the source is still active.
- R8: The software gate at 0x64 is read/write. `irq_o` is a registered OR of the summary bits whose gate bit (bits 0..2) is 0. Writing 0xFFFFFFFF blocks it and writing 0xFFFFFFF8 passes all three.
- R9: If a clear and an event hit the same cause bit in the same cycle, the bit stays set.
- R10: Reads of unmapped addresses (any address at or above 0x80, offsets 0x18..0x1C in a group, or 0x68..0x7C) return 0. Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| ev_rx_i | input | 32 | Receive group event pulses |
| ev_tx_i | input | 32 | Transmit group event pulses |
| ev_misc_i | input | 32 | Miscellaneous group event pulses |
| irq_o | output | 1 | Level host interrupt |

## Verification
The bound checker covers several properties on every cycle. An event always lands in the cause register. A set-mask write always leaves the written bits set. A summary read with no active source always empties the summary. A rising interrupt always has a pending summary bit behind it, and a gate that blocks everything keeps the line low. Unmapped reads always return zero. Only the directed scenarios show the per-bit interplay of clear modes with cause and masked-cause reads, the event-wins collision, the sticky summary surviving a cleared source, and the exact reset values.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned N_GRP    = 3;
  localparam int unsigned GRP_RX   = 0;
  localparam int unsigned GRP_TX   = 1;
  localparam int unsigned GRP_MISC = 2;

  // word offsets inside a group window (address bits [4:2])
  typedef enum logic [2:0] {
    OFS_CAUSE  = 3'd0,
    OFS_MSET   = 3'd1,
    OFS_MCLR   = 3'd2,
    OFS_MVAL   = 3'd3,
    OFS_MCAUSE = 3'd4,
    OFS_MODE   = 3'd5
  } grp_ofs_e;

  // slot 3 (address bits [6:5]) holds the summary registers
  localparam logic [1:0] TOP_SLOT   = 2'd3;
  localparam logic [2:0] OFS_PSEUDO = 3'd0;
  localparam logic [2:0] OFS_GATE   = 3'd1;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_grp.sv
module irq_grp #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ev_i,
  input  logic          wr_cause_i,
  input  logic          wr_mcause_i,
  input  logic          wr_mset_i,
  input  logic          wr_mclr_i,
  input  logic          wr_mode_i,
  input  logic          rd_cause_i,
  input  logic          rd_mcause_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cause_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] mcause_o,
  output logic          any_o
);
  logic [DW-1:0] cause_q, cause_d, mask_q, mask_d, mode_q, mode_d;
  logic [DW-1:0] clr_vec, w1c_vec, cor_vec;
  logic          cause_en, mask_en, mode_en;

  always_comb begin
    w1c_vec = '0;
    cor_vec = '0;
    if (wr_cause_i)  w1c_vec = w1c_vec | (wdata_i & ~mode_q);
    if (wr_mcause_i) w1c_vec = w1c_vec | (wdata_i & ~mode_q & ~mask_q);
    if (rd_cause_i)  cor_vec = cor_vec | mode_q;
    if (rd_mcause_i) cor_vec = cor_vec | (mode_q & ~mask_q);
    clr_vec  = w1c_vec | cor_vec;
    // events are ORed in after clearing: a colliding event wins
    cause_d  = (cause_q & ~clr_vec) | ev_i;
    cause_en = (|clr_vec) | (|ev_i);
  end

  always_comb begin
    mask_d = mask_q;
    if (wr_mset_i) mask_d = mask_d | wdata_i;
    if (wr_mclr_i) mask_d = mask_d & ~wdata_i;
    mask_en = wr_mset_i | wr_mclr_i;
    mode_d  = wdata_i;
    mode_en = wr_mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  assign cause_o  = cause_q;
  assign mask_o   = mask_q;
  assign mode_o   = mode_q;
  assign mcause_o = cause_q & ~mask_q;
  assign any_o    = |(cause_q & ~mask_q);
endmodule

// File: rtl/irq_sum.sv
module irq_sum #(
  parameter int unsigned DW = 32,
  parameter int unsigned NG = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NG-1:0] grp_any_i,
  input  logic          rd_pseudo_i,
  input  logic          wr_gate_i,
  input  logic [DW-1:0] wdata_i,
  output logic [NG-1:0] pseudo_o,
  output logic [DW-1:0] gate_o,
  output logic          irq_o
);
  logic [NG-1:0] pseudo_q, pseudo_d;
  logic [DW-1:0] gate_q;
  logic          irq_q, irq_d;

  always_comb begin
    pseudo_d = pseudo_q;
    if (rd_pseudo_i) pseudo_d = '0;
    pseudo_d = pseudo_d | grp_any_i;
    irq_d    = |(pseudo_q & ~gate_q[NG-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pseudo_q <= '0;
    else        pseudo_q <= pseudo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gate_q <= '1;
    else if (wr_gate_i) gate_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign pseudo_o = pseudo_q;
  assign gate_o   = gate_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [DW-1:0] ev_rx_i,
  input  logic [DW-1:0] ev_tx_i,
  input  logic [DW-1:0] ev_misc_i,
  output logic          irq_o
);
  logic                     rst_sync_n;
  logic                     hi_zero;
  logic [1:0]               slot;
  logic [2:0]               ofs;
  logic [N_GRP-1:0][DW-1:0] ev_a, g_cause, g_mask, g_mode, g_mcause;
  logic [N_GRP-1:0]         g_any, g_sel;
  logic [N_GRP-1:0]         wr_cause, wr_mcause, wr_mset, wr_mclr, wr_mode;
  logic [N_GRP-1:0]         rd_cause, rd_mcause;
  logic                     top_sel, rd_pseudo, wr_gate;
  logic [N_GRP-1:0]         pseudo;
  logic [DW-1:0]            gate;
  logic [DW-1:0]            rdata_d, rdata_q;
  logic                     unused_addr_lsb;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign unused_addr_lsb = ^bus_addr_i[1:0];
  assign hi_zero = (bus_addr_i[AW-1:7] == '0);
  assign slot    = bus_addr_i[6:5];
  assign ofs     = bus_addr_i[4:2];
  assign top_sel = hi_zero && (slot == TOP_SLOT);

  assign ev_a[GRP_RX]   = ev_rx_i;
  assign ev_a[GRP_TX]   = ev_tx_i;
  assign ev_a[GRP_MISC] = ev_misc_i;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign g_sel[g]     = hi_zero && (slot == 2'(g));
    assign wr_cause[g]  = bus_wr_i && g_sel[g] && (ofs == OFS_CAUSE);
    assign wr_mcause[g] = bus_wr_i && g_sel[g] && (ofs == OFS_MCAUSE);
    assign wr_mset[g]   = bus_wr_i && g_sel[g] && (ofs == OFS_MSET);
    assign wr_mclr[g]   = bus_wr_i && g_sel[g] && (ofs == OFS_MCLR);
    assign wr_mode[g]   = bus_wr_i && g_sel[g] && (ofs == OFS_MODE);
    assign rd_cause[g]  = bus_rd_i && g_sel[g] && (ofs == OFS_CAUSE);
    assign rd_mcause[g] = bus_rd_i && g_sel[g] && (ofs == OFS_MCAUSE);

    irq_grp #(.DW(DW)) u_grp (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .ev_i        (ev_a[g]),
      .wr_cause_i  (wr_cause[g]),
      .wr_mcause_i (wr_mcause[g]),
      .wr_mset_i   (wr_mset[g]),
      .wr_mclr_i   (wr_mclr[g]),
      .wr_mode_i   (wr_mode[g]),
      .rd_cause_i  (rd_cause[g]),
      .rd_mcause_i (rd_mcause[g]),
      .wdata_i     (bus_wdata_i),
      .cause_o     (g_cause[g]),
      .mask_o      (g_mask[g]),
      .mode_o      (g_mode[g]),
      .mcause_o    (g_mcause[g]),
      .any_o       (g_any[g])
    );
  end

  assign rd_pseudo = bus_rd_i && top_sel && (ofs == OFS_PSEUDO);
  assign wr_gate   = bus_wr_i && top_sel && (ofs == OFS_GATE);

  irq_sum #(.DW(DW), .NG(N_GRP)) u_sum (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .grp_any_i   (g_any),
    .rd_pseudo_i (rd_pseudo),
    .wr_gate_i   (wr_gate),
    .wdata_i     (bus_wdata_i),
    .pseudo_o    (pseudo),
    .gate_o      (gate),
    .irq_o       (irq_o)
  );

  always_comb begin
    rdata_d = '0;
    if (top_sel) begin
      if (ofs == OFS_PSEUDO)    rdata_d = DW'(pseudo);
      else if (ofs == OFS_GATE) rdata_d = gate;
    end else begin
      for (int g = 0; g < N_GRP; g++) begin
        if (g_sel[g]) begin
          case (ofs)
            OFS_CAUSE:  rdata_d = g_cause[g];
            OFS_MVAL:   rdata_d = g_mask[g];
            OFS_MCAUSE: rdata_d = g_mcause[g];
            OFS_MODE:   rdata_d = g_mode[g];
            default:    rdata_d = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic [DW-1:0] ev_rx,
  input logic [DW-1:0] cause_rx,
  input logic [DW-1:0] mask_rx,
  input logic [2:0]    pseudo,
  input logic [2:0]    grp_any,
  input logic [DW-1:0] gate,
  input logic          irq
);
  logic hi_ok, unmapped;
  assign hi_ok    = (bus_addr[AW-1:7] == '0);
  assign unmapped = !hi_ok
                 || (bus_addr[6:5] != 2'd3 && bus_addr[4:2] > 3'd5)
                 || (bus_addr[6:5] == 2'd3 && bus_addr[4:2] > 3'd1);

  // R2
  ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_rx) |=> ((cause_rx & $past(ev_rx)) == $past(ev_rx)));

  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hi_ok && bus_addr[6:2] == 5'b00001)
      |=> ((mask_rx & $past(bus_wdata)) == $past(bus_wdata)));

  // R7
  pseudo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hi_ok && bus_addr[6:2] == 5'b11000 && grp_any == 3'b000)
      |=> (pseudo == 3'b000));

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(pseudo) != 3'b000));

  // R8
  irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&gate[2:0]) && $past(&gate[2:0])) |-> !irq);

  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && unmapped) |=> (bus_rdata == '0));
endmodule

bind irq_cause_agg irq_agg_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr_i),
  .bus_rd    (bus_rd_i),
  .bus_addr  (bus_addr_i),
  .bus_wdata (bus_wdata_i),
  .bus_rdata (bus_rdata_o),
  .ev_rx     (ev_rx_i),
  .cause_rx  (g_cause[0]),
  .mask_rx   (g_mask[0]),
  .pseudo    (pseudo),
  .grp_any   (g_any),
  .gate      (gate),
  .irq       (irq_o)
);

// File: tb/tb_irq_cause_agg.sv
module tb_irq_cause_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] ev_rx = '0, ev_tx = '0, ev_misc = '0;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_cause_agg dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .ev_rx_i(ev_rx), .ev_tx_i(ev_tx), .ev_misc_i(ev_misc), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic pulse(input int grp, input logic [31:0] v);
    @(negedge clk);
    if (grp == 0) ev_rx = v; else if (grp == 1) ev_tx = v; else ev_misc = v;
    @(negedge clk); ev_rx = '0; ev_tx = '0; ev_misc = '0;
  endtask

  task automatic t_reset;
    rd_chk("R1 rx mask", 8'h0C, 32'hFFFF_FFFF);
    rd_chk("R1 tx mode", 8'h34, 32'h0);
    rd_chk("R1 misc cause", 8'h40, 32'h0);
    rd_chk("R1 pseudo", 8'h60, 32'h0);
    rd_chk("R1 gate", 8'h64, 32'hFFFF_FFFF);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_event_w1c;
    pulse(1, 32'h5);
    rd_chk("R2 tx cause set while masked", 8'h20, 32'h5);
    rd_chk("R2 tx cause not cleared by read in w1c mode", 8'h20, 32'h5);
    wr(8'h20, 32'h1);
    rd_chk("R3 w1c clears written bit", 8'h20, 32'h4);
  endtask

  task automatic t_cor;
    wr(8'h14, 32'h0000_00F0);
    rd_chk("R4 rx mode readback", 8'h14, 32'h0000_00F0);
    pulse(0, 32'h11);
    rd_chk("R4 rx cause first read", 8'h00, 32'h11);
    rd_chk("R4 rx cause after read-clear", 8'h00, 32'h01);
    pulse(0, 32'h10);
    wr(8'h00, 32'h10);
    rd_chk("R3 write ignored on read-clear bit", 8'h00, 32'h11);
    rd_chk("R4 read-clear again", 8'h00, 32'h01);
  endtask

  task automatic t_mask;
    wr(8'h08, 32'hF);
    rd_chk("R5 mask after clear-mask", 8'h0C, 32'hFFFF_FFF0);
    rd_chk("R6 masked view unmasked bit", 8'h10, 32'h1);
    wr(8'h04, 32'h1);
    rd_chk("R5 mask after set-mask", 8'h0C, 32'hFFFF_FFF1);
    rd_chk("R6 masked view hides masked bit", 8'h10, 32'h0);
    wr(8'h08, 32'h1);
    rd_chk("R6 masked view w1c bit kept on read", 8'h10, 32'h1);
  endtask

  task automatic t_masked_cor;
    wr(8'h54, 32'h3);
    wr(8'h48, 32'h1);
    pulse(2, 32'h3);
    rd_chk("R6 misc masked view", 8'h50, 32'h1);
    rd_chk("R6 masked read cleared only unmasked bit", 8'h40, 32'h2);
    rd_chk("R4 misc cause read-clear", 8'h40, 32'h0);
  endtask

  task automatic t_pseudo;
    logic [31:0] v;
    rd(8'h60, v); // flush sticky bits of earlier scenarios
    rd_chk("R7 pseudo rx only, tx masked", 8'h60, 32'h1);
    wr(8'h00, 32'h1);
    rd_chk("R7 pseudo sticky after source cleared", 8'h60, 32'h1);
    rd_chk("R7 pseudo cleared by read", 8'h60, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    pulse(2, 32'h1);
    repeat (2) @(negedge clk);
    check("R8 irq blocked by gate", {31'b0, irq}, 32'h0);
    wr(8'h64, 32'hFFFF_FFF8);
    rd_chk("R8 gate readback", 8'h64, 32'hFFFF_FFF8);
    check("R8 irq raised", {31'b0, irq}, 32'h1);
    wr(8'h64, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 irq dropped when gated", {31'b0, irq}, 32'h0);
    rd(8'h40, v);
    rd(8'h60, v);
    rd_chk("R7 pseudo idle", 8'h60, 32'h0);
  endtask

  task automatic t_collision;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h4; ev_tx = 32'h4;
    @(negedge clk);
    bus_wr = 1'b0; ev_tx = '0;
    rd_chk("R9 event wins over clear", 8'h20, 32'h4);
    wr(8'h20, 32'h4);
    rd_chk("R9 clear alone takes effect", 8'h20, 32'h0);
  endtask

  task automatic t_unmapped;
    rd_chk("R10 read 0x80", 8'h80, 32'h0);
    rd_chk("R10 read group offset 0x18", 8'h18, 32'h0);
    rd_chk("R10 read 0x68", 8'h68, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_event_w1c();
    t_cor();
    t_mask();
    t_masked_cor();
    t_pseudo();
    t_irq();
    t_collision();
    t_unmapped();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule